// File: doc/BRIEF.md
# Thermal Alarm Event Signaller

This block turns raw comparator results from a hardware monitor into three pin-level alarm signals. Up to three over-limit flags, each gated by its own enable, are OR-combined into one over-temperature event; a separate alert flag with its own enable forms the alert event. The over-temperature and alert events each drive an active-low output. A beep output, active high, sounds a square-wave tone while the event it is sourced from is active.

Each of the two active-low outputs runs in one of four modes chosen by a two-bit register input: a steady level while the event lasts, a single fixed-length pulse on every new event, a slow 1 Hz blink for an indicator LED, or an audio-rate tone at 400 Hz or 800 Hz. All waveforms are derived from a system clock whose frequency is a parameter. Each waveform starts in its asserted half on the event's rise and stops at once when the event clears. All outputs are registered. The flags are sampled into an event register, so an input change reaches the pins at the second rising clock edge after it is applied.

Top module: `thermal_alarm_signaller`

## Requirements
- R1: During and right after reset, `ovt_n` and `alert_n` are 1 and `beep` is 0.
- R2: The over-temperature event is the OR of `ovt_flag[i] & ovt_src_en[i]` over all sources. A flag whose enable is 0 has no effect on any output.
- R3: In level mode (mode code 0), an output is 0 from the second rising edge after its event becomes active, and stays 0 while the event remains active.
- R4: In pulse mode (mode code 1), each rising edge of the event gives one low pulse of `pulse_len` cycles, with a value of 0 treated as 1. The pulse length does not depend on how long the event lasts, and no further pulse follows while the event is held.
- R5: In blink mode (mode code 2), the output alternates between low and high, each for CLK_HZ/2 cycles, and starts with its low half.
- R6: In tone mode (mode code 3), the output alternates with a half period of CLK_HZ/800 cycles when its tone-select input is 0 (400 Hz), or CLK_HZ/1600 cycles when it is 1 (800 Hz). It starts with its low half.
- R7: In modes 0, 2 and 3, an output returns to 1 at the second rising edge after its event clears, regardless of the waveform phase.
- R8: While `beep_en` is 1 and the selected event is active, `beep` is a square wave that starts high. `beep_src` 0 selects the over-temperature event and 1 selects the alert event. `beep_tone_hi` picks 800 Hz (1) or 400 Hz (0). Otherwise `beep` is 0 from the second rising edge onward.
- R9: The alert event is `alert_flag & alert_en`. It drives `alert_n` through the same four modes, chosen by `alert_mode` and `alert_tone_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovt_flag | input | NSRC | Over-limit flags from the temperature comparators |
| ovt_src_en | input | NSRC | Per-source enables for the over-temperature event |
| alert_flag | input | 1 | Alert condition flag |
| alert_en | input | 1 | Enable for the alert event |
| ovt_mode | input | 2 | Over-temperature output mode: 0 level, 1 pulse, 2 blink, 3 tone |
| alert_mode | input | 2 | Alert output mode, same encoding |
| ovt_tone_hi | input | 1 | Tone for the over-temperature output: 1 = 800 Hz, 0 = 400 Hz |
| alert_tone_hi | input | 1 | Tone for the alert output: 1 = 800 Hz, 0 = 400 Hz |
| pulse_len | input | PW | Pulse width in clock cycles (0 acts as 1) |
| beep_en | input | 1 | Beep enable |
| beep_src | input | 1 | Beep source: 0 over-temperature, 1 alert |
| beep_tone_hi | input | 1 | Beep tone: 1 = 800 Hz, 0 = 400 Hz |
| ovt_n | output | 1 | Over-temperature output, active low |
| alert_n | output | 1 | Alert output, active low |
| beep | output | 1 | Beep tone output, active high |

## Verification
The assertions check on every cycle the relations that follow directly from the event state: level mode follows its event, the non-pulse modes release as soon as the event clears, the beep stays silent while disabled, and a blink low phase never runs longer than half a blink period. The exact pulse widths, the tone half-periods at both pitches, the start phase of each waveform, the source masking and the beep source selection all depend on long counted sequences. Only the bench's scenarios, sampled at computed cycle offsets, can show those.

// File: rtl/alarm_sig_pkg.sv
package alarm_sig_pkg;
   typedef enum logic [1:0] {
      MODE_LEVEL = 2'd0,
      MODE_PULSE = 2'd1,
      MODE_BLINK = 2'd2,
      MODE_TONE  = 2'd3
   } alarm_mode_e;

   function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                               input int unsigned freq_hz);
      return clk_hz / (2 * freq_hz);
   endfunction
endpackage

// File: rtl/alarm_wave_gen.sv
module alarm_wave_gen #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] half,
   output logic          on
);
   logic [CW-1:0] cnt;
   logic          phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (cnt >= half - CW'(1)) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + CW'(1);
      end
   end

   assign on = run & ~phase;
endmodule

// File: rtl/alarm_combiner.sv
module alarm_combiner #(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] flag,
   input  logic [NSRC-1:0] en,
   output logic            ev
);
   logic [NSRC-1:0] masked;

   for (genvar i = 0; i < NSRC; i++) begin : g_mask
      assign masked[i] = flag[i] & en[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev <= 1'b0;
      else        ev <= |masked;
   end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
   import alarm_sig_pkg::*;
#(
   parameter int CW         = 16,
   parameter int PW         = 8,
   parameter int BLINK_HALF = 8000,
   parameter int T400_HALF  = 20,
   parameter int T800_HALF  = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev,
   input  logic [1:0]    mode,
   input  logic          tone_hi,
   input  logic [PW-1:0] pulse_len,
   output logic          act
);
   alarm_mode_e   mode_e;
   logic          ev_prev;
   logic          rise;
   logic [PW-1:0] pcnt;
   logic [PW-1:0] eff_len;
   logic          blink_on;
   logic          tone_on;
   logic [CW-1:0] tone_half;
   logic          act_d;

   assign mode_e    = alarm_mode_e'(mode);
   assign rise      = ev & ~ev_prev;
   assign eff_len   = (pulse_len == '0) ? PW'(1) : pulse_len;
   assign tone_half = tone_hi ? CW'(T800_HALF) : CW'(T400_HALF);

   alarm_wave_gen #(.CW(CW)) u_blink (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ev),
      .half (CW'(BLINK_HALF)),
      .on   (blink_on)
   );

   alarm_wave_gen #(.CW(CW)) u_tone (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ev),
      .half (tone_half),
      .on   (tone_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_prev <= 1'b0;
         pcnt    <= '0;
      end else begin
         ev_prev <= ev;
         if (rise)             pcnt <= eff_len - PW'(1);
         else if (pcnt != '0)  pcnt <= pcnt - PW'(1);
      end
   end

   always_comb begin
      unique case (mode_e)
         MODE_LEVEL: act_d = ev;
         MODE_PULSE: act_d = rise | (pcnt != '0);
         MODE_BLINK: act_d = blink_on;
         MODE_TONE:  act_d = tone_on;
         default:    act_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act <= 1'b0;
      else        act <= act_d;
   end
endmodule

// File: rtl/thermal_alarm_signaller.sv
module thermal_alarm_signaller
   import alarm_sig_pkg::*;
#(
   parameter int CLK_HZ = 16000,
   parameter int NSRC   = 3,
   parameter int PW     = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] ovt_flag,
   input  logic [NSRC-1:0] ovt_src_en,
   input  logic            alert_flag,
   input  logic            alert_en,
   input  logic [1:0]      ovt_mode,
   input  logic [1:0]      alert_mode,
   input  logic            ovt_tone_hi,
   input  logic            alert_tone_hi,
   input  logic [PW-1:0]   pulse_len,
   input  logic            beep_en,
   input  logic            beep_src,
   input  logic            beep_tone_hi,
   output logic            ovt_n,
   output logic            alert_n,
   output logic            beep
);
   localparam int BLINK_HALF = int'(half_cycles(CLK_HZ, 1));
   localparam int T400_HALF  = int'(half_cycles(CLK_HZ, 400));
   localparam int T800_HALF  = int'(half_cycles(CLK_HZ, 800));
   localparam int CW         = $clog2(BLINK_HALF + 1);

   if (NSRC < 1 || NSRC > 3) begin : g_bad_nsrc
      $error("NSRC must lie between 1 and 3");
   end
   if (T800_HALF < 1) begin : g_bad_clk
      $error("CLK_HZ must be at least 1600");
   end
   if (PW < 1) begin : g_bad_pw
      $error("PW must be at least 1");
   end

   logic ovt_ev;
   logic alert_ev;
   logic ovt_act;
   logic alert_act;
   logic beep_run;
   logic beep_on;

   alarm_combiner #(.NSRC(NSRC)) u_ovt_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .flag (ovt_flag),
      .en   (ovt_src_en),
      .ev   (ovt_ev)
   );

   alarm_combiner #(.NSRC(1)) u_alert_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .flag (alert_flag),
      .en   (alert_en),
      .ev   (alert_ev)
   );

   alarm_channel #(
      .CW(CW), .PW(PW), .BLINK_HALF(BLINK_HALF),
      .T400_HALF(T400_HALF), .T800_HALF(T800_HALF)
   ) u_ovt_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ovt_ev),
      .mode     (ovt_mode),
      .tone_hi  (ovt_tone_hi),
      .pulse_len(pulse_len),
      .act      (ovt_act)
   );

   alarm_channel #(
      .CW(CW), .PW(PW), .BLINK_HALF(BLINK_HALF),
      .T400_HALF(T400_HALF), .T800_HALF(T800_HALF)
   ) u_alert_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (alert_ev),
      .mode     (alert_mode),
      .tone_hi  (alert_tone_hi),
      .pulse_len(pulse_len),
      .act      (alert_act)
   );

   assign beep_run = beep_en & (beep_src ? alert_ev : ovt_ev);

   alarm_wave_gen #(.CW(CW)) u_beep_gen (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (beep_run),
      .half (beep_tone_hi ? CW'(T800_HALF) : CW'(T400_HALF)),
      .on   (beep_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beep <= 1'b0;
      else        beep <= beep_on;
   end

   assign ovt_n   = ~ovt_act;
   assign alert_n = ~alert_act;
endmodule

// File: rtl/thermal_alarm_chk.sv
module thermal_alarm_chk #(
   parameter int BLINK_HALF = 8000,
   parameter int CW         = 14
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ovt_ev,
   input logic       alert_ev,
   input logic [1:0] ovt_mode,
   input logic [1:0] alert_mode,
   input logic       beep_en,
   input logic       ovt_n,
   input logic       alert_n,
   input logic       beep
);
   logic [CW:0] run_len;
   logic [1:0]  mode_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len   <= '0;
         mode_prev <= 2'd0;
      end else begin
         mode_prev <= ovt_mode;
         if (ovt_n || ovt_mode != mode_prev)  run_len <= '0;
         else if (run_len != '1)              run_len <= run_len + 1'b1;
      end
   end

   assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovt_mode == 2'd0 && ovt_ev) |=> !ovt_n);

   assert_ovt_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovt_mode != 2'd1 && !ovt_ev) |=> ovt_n);

   assert_alert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_mode != 2'd1 && !alert_ev) |=> alert_n);

   assert_beep_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !beep_en |=> !beep);

   assert_blink_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovt_mode == 2'd2) |-> (run_len <= (CW+1)'(BLINK_HALF)));
endmodule

bind thermal_alarm_signaller thermal_alarm_chk #(
   .BLINK_HALF(BLINK_HALF), .CW(CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ovt_ev    (ovt_ev),
   .alert_ev  (alert_ev),
   .ovt_mode  (ovt_mode),
   .alert_mode(alert_mode),
   .beep_en   (beep_en),
   .ovt_n     (ovt_n),
   .alert_n   (alert_n),
   .beep      (beep)
);

// File: tb/thermal_alarm_signaller_test.sv
module thermal_alarm_signaller_test;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 16000;
   localparam int NSRC       = 3;
   localparam int PW         = 8;
   localparam int BLINK_H    = CLK_HZ / 2;
   localparam int T400_H     = CLK_HZ / 800;
   localparam int T800_H     = CLK_HZ / 1600;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] ovt_flag = '0;
   logic [NSRC-1:0] ovt_src_en = '0;
   logic            alert_flag = 1'b0;
   logic            alert_en = 1'b0;
   logic [1:0]      ovt_mode = 2'd0;
   logic [1:0]      alert_mode = 2'd0;
   logic            ovt_tone_hi = 1'b0;
   logic            alert_tone_hi = 1'b0;
   logic [PW-1:0]   pulse_len = '0;
   logic            beep_en = 1'b0;
   logic            beep_src = 1'b0;
   logic            beep_tone_hi = 1'b0;
   logic            ovt_n;
   logic            alert_n;
   logic            beep;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thermal_alarm_signaller #(.CLK_HZ(CLK_HZ), .NSRC(NSRC), .PW(PW)) uut (
      .clk(clk), .rst_n(rst_n), .ovt_flag(ovt_flag), .ovt_src_en(ovt_src_en),
      .alert_flag(alert_flag), .alert_en(alert_en), .ovt_mode(ovt_mode),
      .alert_mode(alert_mode), .ovt_tone_hi(ovt_tone_hi),
      .alert_tone_hi(alert_tone_hi), .pulse_len(pulse_len),
      .beep_en(beep_en), .beep_src(beep_src), .beep_tone_hi(beep_tone_hi),
      .ovt_n(ovt_n), .alert_n(alert_n), .beep(beep)
   );

   // vector: ovt_flag[3], ovt_src_en[3], alert_flag, alert_en, exp ovt_n, exp alert_n
   localparam int NVEC = 7;
   localparam logic [9:0] VEC [NVEC] = '{
      10'b000_111_0_1_1_1,
      10'b001_001_0_1_0_1,
      10'b010_101_0_1_1_1,
      10'b100_100_1_1_0_0,
      10'b110_001_1_0_1_1,
      10'b111_000_0_1_1_1,
      10'b011_010_1_1_0_0
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // advance n falling edges
   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic idle();
      ovt_flag = '0; alert_flag = 1'b0; beep_en = 1'b0;
      negs(4);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      negs(3);
      check("R1 ovt_n in reset", ovt_n, 1'b1);
      check("R1 alert_n in reset", alert_n, 1'b1);
      check("R1 beep in reset", beep, 1'b0);
      rst_n = 1'b1;
      negs(2);
      check("R1 ovt_n after reset", ovt_n, 1'b1);

      // level-mode table, R2 / R3 / R9
      for (int v = 0; v < NVEC; v++) begin
         {ovt_flag, ovt_src_en, alert_flag, alert_en} = VEC[v][9:2];
         negs(2);
         check("R2 R3 table ovt_n", ovt_n, VEC[v][1]);
         check("R9 table alert_n", alert_n, VEC[v][0]);
      end
      idle();

      // latency and release in level mode, R3 / R7
      ovt_src_en = 3'b111; ovt_flag = 3'b100;
      negs(1);
      check("R3 no output after one edge", ovt_n, 1'b1);
      negs(1);
      check("R3 low after two edges", ovt_n, 1'b0);
      negs(10);
      check("R3 held low", ovt_n, 1'b0);
      ovt_flag = '0;
      negs(1);
      check("R7 level still low after one edge", ovt_n, 1'b0);
      negs(1);
      check("R7 level released", ovt_n, 1'b1);
      idle();

      // pulse mode length 5, R4
      ovt_mode = 2'd1; pulse_len = 8'd5; ovt_flag = 3'b001;
      negs(2);  check("R4 pulse starts", ovt_n, 1'b0);
      negs(4);  check("R4 pulse last cycle", ovt_n, 1'b0);
      negs(1);  check("R4 pulse ended", ovt_n, 1'b1);
      negs(20); check("R4 no repeat while held", ovt_n, 1'b1);
      ovt_flag = '0; negs(4);
      ovt_flag = 3'b010; negs(1); ovt_flag = '0;   // one-cycle event
      negs(1);  check("R4 short event pulse", ovt_n, 1'b0);
      negs(4);  check("R4 short event pulse full width", ovt_n, 1'b0);
      negs(1);  check("R4 short event pulse end", ovt_n, 1'b1);
      pulse_len = 8'd0; ovt_flag = 3'b001;
      negs(2);  check("R4 zero length acts as one", ovt_n, 1'b0);
      negs(1);  check("R4 zero length ends", ovt_n, 1'b1);
      idle();

      // blink mode, R5 / R7
      ovt_mode = 2'd2; ovt_flag = 3'b001;
      negs(2);            check("R5 blink starts low", ovt_n, 1'b0);
      negs(BLINK_H - 1);  check("R5 blink end of low half", ovt_n, 1'b0);
      negs(1);            check("R5 blink high half", ovt_n, 1'b1);
      negs(BLINK_H - 1);  check("R5 blink end of high half", ovt_n, 1'b1);
      negs(1);            check("R5 blink low again", ovt_n, 1'b0);
      negs(5);
      ovt_flag = '0;
      negs(2);            check("R7 blink released mid phase", ovt_n, 1'b1);
      idle();

      // tone mode both pitches, R6
      ovt_mode = 2'd3; ovt_tone_hi = 1'b0; ovt_flag = 3'b001;
      negs(2);           check("R6 400 Hz starts low", ovt_n, 1'b0);
      negs(T400_H - 1);  check("R6 400 Hz low half end", ovt_n, 1'b0);
      negs(1);           check("R6 400 Hz high half", ovt_n, 1'b1);
      negs(T400_H);      check("R6 400 Hz low again", ovt_n, 1'b0);
      idle();
      ovt_tone_hi = 1'b1; ovt_flag = 3'b001;
      negs(2);           check("R6 800 Hz starts low", ovt_n, 1'b0);
      negs(T800_H - 1);  check("R6 800 Hz low half end", ovt_n, 1'b0);
      negs(1);           check("R6 800 Hz high half", ovt_n, 1'b1);
      negs(T800_H);      check("R6 800 Hz low again", ovt_n, 1'b0);
      idle();
      ovt_mode = 2'd0;

      // alert in tone mode, R9
      alert_mode = 2'd3; alert_tone_hi = 1'b1; alert_en = 1'b1; alert_flag = 1'b1;
      negs(2);           check("R9 alert tone starts low", alert_n, 1'b0);
      negs(T800_H);      check("R9 alert tone high half", alert_n, 1'b1);
      alert_flag = 1'b0;
      negs(2);           check("R9 alert tone released", alert_n, 1'b1);
      idle();
      alert_mode = 2'd0;

      // beep, R8
      beep_src = 1'b1; beep_tone_hi = 1'b1; beep_en = 1'b1; alert_flag = 1'b1;
      negs(2);           check("R8 beep starts high", beep, 1'b1);
      negs(T800_H - 1);  check("R8 beep high half end", beep, 1'b1);
      negs(1);           check("R8 beep low half", beep, 1'b0);
      negs(T800_H);      check("R8 beep high again", beep, 1'b1);
      alert_flag = 1'b0; ovt_flag = 3'b001;
      negs(3);           check("R8 beep ignores unselected source", beep, 1'b0);
      beep_src = 1'b0; beep_tone_hi = 1'b0;
      negs(2);           check("R8 beep follows ovt source", beep, 1'b1);
      negs(T400_H);      check("R8 beep 400 Hz low half", beep, 1'b0);
      beep_en = 1'b0;
      negs(2);           check("R8 beep disabled", beep, 1'b0);
      idle();

      // reset mid-event, R1
      ovt_flag = 3'b001; negs(3);
      rst_n = 1'b0; negs(1);
      check("R1 reset clears active output", ovt_n, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule